// File: doc/BRIEF.md
# Host Adapter Interrupt and Status Unit

This block holds the interrupt-cause, status and sequence-step registers of a bus host adapter and drives its level interrupt line. Internal logic posts events into it: a generic event that loads a cause, a sequence step and FIFO flags, a bus-phase update, a transfer-count load, a DMA-done notice and a command-completion notice carrying a status byte. The host sees the registers through a byte-wide read port. A read of the cause register acknowledges the interrupt.

A completion that arrives while an interrupt is still pending is not applied. The block latches its status byte and waits for the host to acknowledge. The acknowledging read clears the cause register and drops the line. In the same clock edge, the held completion is then applied and the interrupt is raised again. This keeps the host from missing the completion while it is still servicing the earlier cause.

Top module: `hba_irq_status`

## Requirements
- R1: A synchronous active-high reset clears every register, the deferred-completion flag and the interrupt line. Every read address then returns 0.
- R2: Raising the interrupt sets status bit 7 and asserts `irq`. The `irq` line always equals status bit 7 one cycle after the edge. Raising while the bit is already set changes nothing else. Lowering clears both.
- R3: A read with `rd_addr`=0 returns the cause value held before that edge. At the edge it clears the cause to 0, clears status bit 4 (terminal count), sets the sequence step to 4 (command done) and lowers the interrupt.
- R4: A completion arriving while status bit 7 is set is not applied. Cause, status, sequence step, flags, count and completion byte stay as they were. Its status byte is held and the deferred flag is set. A later deferred completion overwrites the held byte.
- R5: On an acknowledging read with a deferred completion held, the held completion is applied on that same edge and the flag clears. `irq` is therefore high again after that edge.
- R6: Applying a completion sets status to the status phase (bits 2:0 = 3'b011) with all other bits clear, then performs the DMA-done update of R10. It also stores the status byte at read address 7. The result is status 8'h93 and cause 8'h10.
- R7: A completion in the same cycle as an acknowledging read with nothing deferred is applied at once and not deferred.
- R8: A posted event loads cause, sequence step (3 bits, read address 2) and FIFO flags (5 bits, read address 3). It raises the interrupt only when `post_raise` is 1.
- R9: A count load stores the transfer count, readable least significant byte first at addresses 4, 5 and 6. It clears status bit 4.
- R10: A DMA-done event sets status bit 4 and keeps the phase bits. It sets the cause to 8'h10 (bus service). It zeroes the sequence step, the flags and the transfer count, and raises the interrupt.
- R11: Reads at addresses 1 to 7 have no side effect.
- R12: Events in one cycle take effect in this order: acknowledge, deferred release, phase update, count load, posted event, DMA done, completion. A completion in the same cycle as a release is deferred again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | ADDR_W | Register address (0 cause, 1 status, 2 step, 3 flags, 4..6 count, 7 completion byte) |
| rd_data | output | 8 | Register value before the edge |
| post_valid | input | 1 | Generic event strobe |
| post_cause | input | 8 | Cause value for the event |
| post_seq | input | 3 | Sequence step for the event |
| post_flags | input | 5 | FIFO flags for the event |
| post_raise | input | 1 | Event raises the interrupt |
| phase_valid | input | 1 | Bus phase update strobe |
| phase_val | input | 3 | New bus phase |
| cnt_load | input | 1 | Transfer count load strobe |
| cnt_val | input | 8*CNT_BYTES | Transfer count value |
| dma_done | input | 1 | DMA-done event |
| cmpl_valid | input | 1 | Command completion event |
| cmpl_status | input | 8 | Completion status byte |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default three-byte transfer count, so read address 7 holds the completion byte. The whole register map fits in one sweep of addresses. With that width, the count bytes prove byte order and that they are cleared by completion. A behavioural model predicts every register on every clock. The stimulus covers the edge cases where deferral matters: an acknowledge together with a fresh completion, and a release followed by a re-deferral in one cycle.

// File: rtl/hba_irq_pkg.sv
package hba_irq_pkg;

    localparam int unsigned ST_INT_BIT = 7;
    localparam int unsigned ST_TC_BIT  = 4;

    localparam logic [7:0] CAUSE_BUSRST = 8'h80;
    localparam logic [7:0] CAUSE_DISC   = 8'h20;
    localparam logic [7:0] CAUSE_BSVC   = 8'h10;
    localparam logic [7:0] CAUSE_FDONE  = 8'h08;

    localparam logic [2:0] PHASE_STATUS = 3'b011;
    localparam logic [2:0] STEP_DONE    = 3'd4;

    localparam int unsigned FLAG_W = 5;

    typedef enum logic [2:0] {
        RA_CAUSE  = 3'd0,
        RA_STATUS = 3'd1,
        RA_STEP   = 3'd2,
        RA_FLAGS  = 3'd3,
        RA_COUNT0 = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [7:0]        cause;
        logic [7:0]        status;
        logic [2:0]        step;
        logic [FLAG_W-1:0] flags;
        logic [7:0]        cbyte;
    } regs_t;

    function automatic logic [7:0] f_raise(input logic [7:0] st);
        return st | (8'h01 << ST_INT_BIT);
    endfunction

    function automatic logic [7:0] f_lower(input logic [7:0] st);
        return st & ~(8'h01 << ST_INT_BIT);
    endfunction

endpackage

// File: rtl/hba_irq_defer.sv
module hba_irq_defer (
    input  logic       clk,
    input  logic       rst,
    input  logic       hold_load,
    input  logic [7:0] hold_status,
    input  logic       hold_drop,
    output logic       pend_q,
    output logic [7:0] pend_status_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q        <= 1'b0;
            pend_status_q <= 8'h00;
        end else if (hold_load) begin
            pend_q        <= 1'b1;
            pend_status_q <= hold_status;
        end else if (hold_drop) begin
            pend_q        <= 1'b0;
        end
    end

    p_load_sets_r4: assert property (@(posedge clk) disable iff (rst)
        hold_load |=> pend_q);
    p_drop_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (hold_drop && !hold_load) |=> !pend_q);
endmodule

// File: rtl/hba_irq_core.sv
module hba_irq_core
    import hba_irq_pkg::*;
#(
    parameter int unsigned CNT_BYTES = 3,
    localparam int unsigned CNT_W    = 8 * CNT_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ack,
    input  logic              post_valid,
    input  logic [7:0]        post_cause,
    input  logic [2:0]        post_seq,
    input  logic [FLAG_W-1:0] post_flags,
    input  logic              post_raise,
    input  logic              phase_valid,
    input  logic [2:0]        phase_val,
    input  logic              cnt_load,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              dma_done,
    input  logic              cmpl_valid,
    input  logic [7:0]        cmpl_status,
    input  logic              pend_q,
    input  logic [7:0]        pend_status_q,
    output logic              hold_load,
    output logic [7:0]        hold_status,
    output logic              hold_drop,
    output regs_t             regs_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              irq_q
);
    regs_t            r_n;
    logic [CNT_W-1:0] c_n;

    always_comb begin
        r_n         = regs_q;
        c_n         = cnt_q;
        hold_load   = 1'b0;
        hold_status = cmpl_status;
        hold_drop   = 1'b0;

        if (ack) begin
            r_n.cause             = 8'h00;
            r_n.status[ST_TC_BIT] = 1'b0;
            r_n.step              = STEP_DONE;
            r_n.status            = f_lower(r_n.status);
            if (pend_q) begin
                hold_drop             = 1'b1;
                r_n.status            = {5'b0, PHASE_STATUS};
                r_n.cbyte             = pend_status_q;
                r_n.status[ST_TC_BIT] = 1'b1;
                r_n.cause             = CAUSE_BSVC;
                r_n.step              = 3'd0;
                r_n.flags             = '0;
                c_n                   = '0;
                r_n.status            = f_raise(r_n.status);
            end
        end

        if (phase_valid) begin
            r_n.status[2:0] = phase_val;
        end

        if (cnt_load) begin
            c_n                   = cnt_val;
            r_n.status[ST_TC_BIT] = 1'b0;
        end

        if (post_valid) begin
            r_n.cause = post_cause;
            r_n.step  = post_seq;
            r_n.flags = post_flags;
            if (post_raise) begin
                r_n.status = f_raise(r_n.status);
            end
        end

        if (dma_done) begin
            r_n.status[ST_TC_BIT] = 1'b1;
            r_n.cause             = CAUSE_BSVC;
            r_n.step              = 3'd0;
            r_n.flags             = '0;
            c_n                   = '0;
            r_n.status            = f_raise(r_n.status);
        end

        if (cmpl_valid) begin
            if (r_n.status[ST_INT_BIT]) begin
                hold_load = 1'b1;
            end else begin
                r_n.status            = {5'b0, PHASE_STATUS};
                r_n.cbyte             = cmpl_status;
                r_n.status[ST_TC_BIT] = 1'b1;
                r_n.cause             = CAUSE_BSVC;
                r_n.step              = 3'd0;
                r_n.flags             = '0;
                c_n                   = '0;
                r_n.status            = f_raise(r_n.status);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
            cnt_q  <= '0;
            irq_q  <= 1'b0;
        end else begin
            regs_q <= r_n;
            cnt_q  <= c_n;
            irq_q  <= r_n.status[ST_INT_BIT];
        end
    end

    // R3: a plain acknowledge drops the line and clears the cause
    p_ack_lowers_r3: assert property (@(posedge clk) disable iff (rst)
        (ack && !pend_q && !post_valid && !dma_done && !cmpl_valid)
        |=> (!irq_q && regs_q.cause == 8'h00 && regs_q.step == STEP_DONE));

    // R4: a completion against a pending interrupt leaves status untouched
    p_defer_keeps_r4: assert property (@(posedge clk) disable iff (rst)
        (cmpl_valid && irq_q && !ack && !post_valid && !dma_done
         && !phase_valid && !cnt_load)
        |=> $stable(regs_q) && $stable(cnt_q));

    // R5: releasing a held completion raises the line again
    p_release_raises_r5: assert property (@(posedge clk) disable iff (rst)
        (ack && pend_q) |=> irq_q);

    // R2: the line only rises after an event that may raise it
    p_rise_cause_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> $past(post_raise || dma_done || cmpl_valid || (ack && pend_q)));

    // R9: a lone count load leaves terminal count clear
    p_load_clears_tc_r9: assert property (@(posedge clk) disable iff (rst)
        (cnt_load && !dma_done && !cmpl_valid && !(ack && pend_q))
        |=> !regs_q.status[ST_TC_BIT]);
endmodule

// File: rtl/hba_irq_rdmux.sv
module hba_irq_rdmux
    import hba_irq_pkg::*;
#(
    parameter int unsigned CNT_BYTES = 3,
    localparam int unsigned CNT_W    = 8 * CNT_BYTES,
    localparam int unsigned ADDR_W   = $clog2(CNT_BYTES + 5)
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  regs_t             regs_q,
    input  logic [CNT_W-1:0]  cnt_q,
    output logic [7:0]        rd_data
);
    localparam int unsigned CB_ADDR = 4 + CNT_BYTES;

    logic [7:0] cnt_sel;

    always_comb begin
        cnt_sel = 8'h00;
        for (int i = 0; i < CNT_BYTES; i++) begin
            if (rd_addr == ADDR_W'(int'(RA_COUNT0) + i)) begin
                cnt_sel = cnt_q[8*i +: 8];
            end
        end
    end

    always_comb begin
        unique case (rd_addr)
            ADDR_W'(RA_CAUSE):  rd_data = regs_q.cause;
            ADDR_W'(RA_STATUS): rd_data = regs_q.status;
            ADDR_W'(RA_STEP):   rd_data = {5'b0, regs_q.step};
            ADDR_W'(RA_FLAGS):  rd_data = {{(8 - FLAG_W){1'b0}}, regs_q.flags};
            ADDR_W'(CB_ADDR):   rd_data = regs_q.cbyte;
            default:            rd_data = cnt_sel;
        endcase
    end
endmodule

// File: rtl/hba_irq_status.sv
module hba_irq_status
    import hba_irq_pkg::*;
#(
    parameter int unsigned CNT_BYTES = 3,
    localparam int unsigned CNT_W    = 8 * CNT_BYTES,
    localparam int unsigned ADDR_W   = $clog2(CNT_BYTES + 5)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              post_valid,
    input  logic [7:0]        post_cause,
    input  logic [2:0]        post_seq,
    input  logic [4:0]        post_flags,
    input  logic              post_raise,
    input  logic              phase_valid,
    input  logic [2:0]        phase_val,
    input  logic              cnt_load,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              dma_done,
    input  logic              cmpl_valid,
    input  logic [7:0]        cmpl_status,
    output logic              irq
);
    logic             ack;
    logic             pend_q;
    logic [7:0]       pend_status_q;
    logic             hold_load;
    logic [7:0]       hold_status;
    logic             hold_drop;
    regs_t            regs_q;
    logic [CNT_W-1:0] cnt_q;

    assign ack = rd_en && (rd_addr == ADDR_W'(RA_CAUSE));

    hba_irq_core #(.CNT_BYTES(CNT_BYTES)) core_i (
        .clk(clk), .rst(rst), .ack(ack),
        .post_valid(post_valid), .post_cause(post_cause), .post_seq(post_seq),
        .post_flags(post_flags), .post_raise(post_raise),
        .phase_valid(phase_valid), .phase_val(phase_val),
        .cnt_load(cnt_load), .cnt_val(cnt_val), .dma_done(dma_done),
        .cmpl_valid(cmpl_valid), .cmpl_status(cmpl_status),
        .pend_q(pend_q), .pend_status_q(pend_status_q),
        .hold_load(hold_load), .hold_status(hold_status), .hold_drop(hold_drop),
        .regs_q(regs_q), .cnt_q(cnt_q), .irq_q(irq)
    );

    hba_irq_defer defer_i (
        .clk(clk), .rst(rst),
        .hold_load(hold_load), .hold_status(hold_status), .hold_drop(hold_drop),
        .pend_q(pend_q), .pend_status_q(pend_status_q)
    );

    hba_irq_rdmux #(.CNT_BYTES(CNT_BYTES)) rdmux_i (
        .rd_addr(rd_addr), .regs_q(regs_q), .cnt_q(cnt_q), .rd_data(rd_data)
    );

    // R11: a non-acknowledging read with no events changes no register
    p_read_no_effect_r11: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr != ADDR_W'(RA_CAUSE) && !post_valid && !phase_valid
         && !cnt_load && !dma_done && !cmpl_valid)
        |=> $stable(regs_q) && $stable(irq));

    // R2: line follows the interrupt status bit
    p_line_matches_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == rd_status_bit()));

    function automatic logic rd_status_bit();
        return regs_q.status[ST_INT_BIT];
    endfunction
endmodule

// File: tb/hba_irq_status_tb_top.sv
module hba_irq_status_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_BYTES  = 3;
    localparam int CNT_W      = 8 * CNT_BYTES;
    localparam int ADDR_W     = $clog2(CNT_BYTES + 5);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [7:0]        rd_data;
    logic              post_valid = 1'b0;
    logic [7:0]        post_cause = '0;
    logic [2:0]        post_seq = '0;
    logic [4:0]        post_flags = '0;
    logic              post_raise = 1'b0;
    logic              phase_valid = 1'b0;
    logic [2:0]        phase_val = '0;
    logic              cnt_load = 1'b0;
    logic [CNT_W-1:0]  cnt_val = '0;
    logic              dma_done = 1'b0;
    logic              cmpl_valid = 1'b0;
    logic [7:0]        cmpl_status = '0;
    logic              irq;

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural model
    logic [7:0]       m_cause, m_st, m_cb, m_pst;
    logic [2:0]       m_seq;
    logic [4:0]       m_flags;
    logic [CNT_W-1:0] m_cnt;
    logic             m_pend;

    always #(CLK_PERIOD/2) clk = ~clk;

    hba_irq_status #(.CNT_BYTES(CNT_BYTES)) dut_i (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .post_valid(post_valid), .post_cause(post_cause), .post_seq(post_seq),
        .post_flags(post_flags), .post_raise(post_raise),
        .phase_valid(phase_valid), .phase_val(phase_val),
        .cnt_load(cnt_load), .cnt_val(cnt_val), .dma_done(dma_done),
        .cmpl_valid(cmpl_valid), .cmpl_status(cmpl_status), .irq(irq)
    );

    function automatic logic [7:0] m_read(input int a);
        if (a == 0) return m_cause;
        if (a == 1) return m_st;
        if (a == 2) return {5'b0, m_seq};
        if (a == 3) return {3'b0, m_flags};
        if (a >= 4 && a < 4 + CNT_BYTES) return m_cnt[8*(a-4) +: 8];
        if (a == 4 + CNT_BYTES) return m_cb;
        return 8'h00;
    endfunction

    task automatic m_dma_done();
        m_st[4] = 1'b1; m_cause = 8'h10; m_seq = 3'd0; m_flags = 5'd0;
        m_cnt = '0; m_st[7] = 1'b1;
    endtask

    task automatic m_complete(input logic [7:0] s);
        m_st = 8'h03; m_cb = s;
        m_dma_done();
    endtask

    task automatic m_clear();
        m_cause = 0; m_st = 0; m_cb = 0; m_pst = 0; m_seq = 0; m_flags = 0;
        m_cnt = 0; m_pend = 0;
    endtask

    task automatic m_step();
        if (rst) begin
            m_clear();
            return;
        end
        if (rd_en && rd_addr == 0) begin
            m_cause = 0; m_st[4] = 0; m_seq = 3'd4; m_st[7] = 0;
            if (m_pend) begin m_complete(m_pst); m_pend = 0; end
        end
        if (phase_valid) m_st[2:0] = phase_val;
        if (cnt_load) begin m_cnt = cnt_val; m_st[4] = 0; end
        if (post_valid) begin
            m_cause = post_cause; m_seq = post_seq; m_flags = post_flags;
            if (post_raise) m_st[7] = 1'b1;
        end
        if (dma_done) m_dma_done();
        if (cmpl_valid) begin
            if (m_st[7]) begin m_pend = 1; m_pst = cmpl_status; end
            else m_complete(cmpl_status);
        end
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp,
                         input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    // one clock: inputs are already driven at the falling edge
    task automatic cyc(input string tag);
        #1;
        check(tag, rd_data, m_read(int'(rd_addr)), "rd_data");
        check(tag, {7'b0, irq}, {7'b0, m_st[7]}, "irq");
        @(posedge clk);
        m_step();
        @(negedge clk);
        rd_en = 0; post_valid = 0; post_raise = 0; phase_valid = 0;
        cnt_load = 0; dma_done = 0; cmpl_valid = 0;
    endtask

    task automatic rd(input int a, input string tag);
        rd_en = 1; rd_addr = ADDR_W'(a);
        cyc(tag);
    endtask

    task automatic sweep(input string tag);
        for (int a = 1; a <= 4 + CNT_BYTES; a++) rd(a, tag);
    endtask

    task automatic post(input logic [7:0] c, input logic [2:0] s,
                        input logic [4:0] f, input logic r);
        post_valid = 1; post_cause = c; post_seq = s; post_flags = f; post_raise = r;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        m_clear();
        @(negedge clk);
        rst = 1; cyc("R1"); cyc("R1");
        rst = 0;
        sweep("R1");
        rd_en = 0; rd_addr = 0; cyc("R1");

        post(8'h08, 3'd2, 5'd3, 1'b1); cyc("R8");
        sweep("R8");
        post(8'h20, 3'd1, 5'd7, 1'b1); cyc("R2");
        sweep("R2");

        phase_valid = 1; phase_val = 3'b001; cyc("R12");
        cnt_load = 1; cnt_val = 24'h123456; cyc("R9");
        sweep("R9");

        cmpl_valid = 1; cmpl_status = 8'h02; cyc("R4");
        sweep("R4");
        cmpl_valid = 1; cmpl_status = 8'h08; cyc("R4");
        rd(1, "R11"); rd(3, "R11");

        rd(0, "R3");
        sweep("R5");
        rd(0, "R5");
        rd(0, "R3");
        sweep("R3");

        cmpl_valid = 1; cmpl_status = 8'h00; cyc("R6");
        sweep("R6");

        rd_en = 1; rd_addr = 0; cmpl_valid = 1; cmpl_status = 8'h18; cyc("R7");
        sweep("R7");
        rd(0, "R3");

        phase_valid = 1; phase_val = 3'b110; cyc("R10");
        cnt_load = 1; cnt_val = 24'hABCDEF; cyc("R9");
        dma_done = 1; cyc("R10");
        sweep("R10");

        cmpl_valid = 1; cmpl_status = 8'h22; cyc("R4");
        rd_en = 1; rd_addr = 0; cmpl_valid = 1; cmpl_status = 8'h44; cyc("R12");
        sweep("R12");
        rd(0, "R12");
        sweep("R12");
        rd(0, "R3");

        post(8'h80, 3'd5, 5'd17, 1'b0); cyc("R8");
        sweep("R8");
        cnt_load = 1; cnt_val = 24'h00FF01; post(8'h08, 3'd3, 5'd1, 1'b1);
        dma_done = 1; cyc("R12");
        sweep("R12");

        rst = 1; cyc("R1");
        rst = 0; sweep("R1");
        rd_en = 0; rd_addr = 0; cyc("R1");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule